// File: doc/BRIEF.md
# Texture Packet Walker

The block collects 32-bit words arriving on a texture write port into an internal word store. When a flush request arrives, it stops taking new words and walks the stored words as a chain of variable-length packets. It forwards each packet to a downstream texture writer over a valid/ready stream. The header word of each packet is flagged with a start marker and its payload words follow in order. Once the walk ends, the store is emptied and the port accepts words again.

A packet's length in words comes from its leading word, which carries a byte count. The length is the byte count halved, plus two, then divided by four, all in integer arithmetic. A zero length ends the walk at once. A store holding too few words at flush time is simply discarded. Words written while the store is full are dropped and raise a sticky overflow flag, which an end-of-frame pulse clears. Each flush also sets a command-written flag. A frame-sync pulse copies that flag into a snapshot output and then clears it.

Top module: `texture_packet_walker`

## Requirements
- R1: A word on `wrData` is stored when `wrValid` and `wrReady` are both high, in arrival order from index 0. `wrReady` is low from the cycle after an accepted flush until the walk has finished. A word written in the same cycle as the flush request is included in that flush.
- R2: The store holds `DEPTH` words. A write while full is dropped and sets `overflowErr`. `overflowErr` stays high until a cycle with `frameEnd` high and no dropped write; a dropped write in a `frameEnd` cycle leaves the flag set.
- R3: An accepted flush (`flushReq` while `wrReady`) sets `cmdWritten`. A `frameSync` cycle loads `cmdSnap` with the current `cmdWritten` and clears `cmdWritten`, except that a flush accepted in the same cycle leaves `cmdWritten` set.
- R4: If the store holds 2 or fewer words at flush, nothing is emitted and the store is emptied.
- R5: For a packet starting at index i, the length is L = (2 + w[i]/2)/4, with w[i] an unsigned 32-bit value and both divisions truncating.
- R6: A packet at index i emits w[i+1] with `outFirst`=1, then w[i+2] up to w[i+L-1] with `outFirst`=0. The payload is cut short at the last stored word.
- R7: If L is zero, the walk ends and nothing more is emitted for that flush.
- R8: The first packet starts at index 0 and the next one at i+L. The walk continues only while the next packet's index is less than the stored count minus 2.
- R9: After a flush completes, the store is empty, so the next written word lands at index 0.
- R10: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outFirst` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write port word valid |
| wrData | input | 32 | Write port word |
| wrReady | output | 1 | Write port can take a word (low during a walk) |
| flushReq | input | 1 | Start a flush/walk (taken while `wrReady`) |
| frameEnd | input | 1 | Clears the overflow flag |
| frameSync | input | 1 | Snapshots and clears the command-written flag |
| outValid | output | 1 | Downstream word valid |
| outFirst | output | 1 | Marks the header word of a packet |
| outData | output | 32 | Downstream word |
| outReady | input | 1 | Downstream accepts the word |
| overflowErr | output | 1 | Sticky dropped-write flag |
| cmdWritten | output | 1 | A flush occurred since the last frame sync |
| cmdSnap | output | 1 | Value of `cmdWritten` captured at the last frame sync |

## Verification
The bench drives packets whose last payload runs past the stored count and checks that the payload is cut at the last stored word; a design that read past the count would emit stale or extra words. It checks zero-length packets both at the start and after a valid packet, and flushes with only two words stored; a wrong design would emit a header or walk garbage. It checks a byte count of all ones, where a narrow length adder would wrap to a small length and emit extra packets. It also checks overflow with a clear in the same cycle, flushes coinciding with frame sync, and stalls on the output; a wrong design would lose the sticky flag, the command flag, or hold data unstably.

// File: rtl/texwalk_pkg.sv
package texwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN, ST_HDR, ST_PAY, ST_NEXT, ST_DONE
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startWalk;
    logic latchLen;
    logic loadPtr;
    logic stepPtr;
    logic nextPkt;
    logic clearCount;
    logic selHdr;
  } walkCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic fewWords;
    logic lenZero;
    logic hdrOnly;
    logic payLast;
    logic nextOk;
  } walkSts_t;

endpackage

// File: rtl/texwalk_store.sv
module texwalk_store
  import texwalk_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          frameEnd,
  input  walkCtl_t      ctl,
  output walkSts_t      sts,
  output logic [DW-1:0] rdData,
  output logic          overflowErr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = DW + 2;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] pktIdx;
  logic [CW-1:0] ptr;
  logic [DW-1:0] lenReg;
  logic [DW-1:0] lenCalc;
  logic [DW-1:0] word0;
  logic [XW-1:0] nxtSum;
  logic [CW-1:0] rdAddr;
  logic          full;

  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (wrEn && !full) mem[count[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      overflowErr <= 1'b0;
      pktIdx      <= '0;
      ptr         <= '0;
      lenReg      <= '0;
    end else begin
      if (ctl.clearCount)      count <= '0;
      else if (wrEn && !full)  count <= count + CW'(1);

      if (wrEn && full)        overflowErr <= 1'b1;
      else if (frameEnd)       overflowErr <= 1'b0;

      if (ctl.startWalk)       pktIdx <= '0;
      else if (ctl.nextPkt)    pktIdx <= nxtSum[CW-1:0];

      if (ctl.latchLen)        lenReg <= lenCalc;

      if (ctl.loadPtr)         ptr <= pktIdx + CW'(2);
      else if (ctl.stepPtr)    ptr <= ptr + CW'(1);
    end
  end

  assign word0   = mem[pktIdx[AW-1:0]];
  assign lenCalc = DW'((XW'(2) + XW'(word0 >> 1)) >> 2);
  assign nxtSum  = XW'(pktIdx) + XW'(lenReg);

  assign sts.fewWords = (count <= CW'(2));
  assign sts.lenZero  = (lenCalc == '0);
  assign sts.hdrOnly  = (lenReg <= DW'(2));
  assign sts.payLast  = ((XW'(ptr) + XW'(1)) >= nxtSum) ||
                        ((XW'(ptr) + XW'(1)) >= XW'(count));
  assign sts.nextOk   = (nxtSum < (XW'(count) - XW'(2)));

  assign rdAddr = ctl.selHdr ? (pktIdx + CW'(1)) : ptr;
  assign rdData = mem[rdAddr[AW-1:0]];

endmodule

// File: rtl/texwalk_ctrl.sv
module texwalk_ctrl
  import texwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flushReq,
  input  logic     frameSync,
  input  logic     outReady,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     wrReady,
  output logic     outValid,
  output logic     outFirst,
  output logic     cmdWritten,
  output logic     cmdSnap
);
  walkState_e state, nextState;
  logic       flushTake;

  assign flushTake = (state == ST_IDLE) && flushReq;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (flushReq) begin
        ctl.startWalk = 1'b1;
        nextState     = ST_LEN;
      end
      ST_LEN: begin
        if (sts.fewWords || sts.lenZero) nextState = ST_DONE;
        else begin
          ctl.latchLen = 1'b1;
          nextState    = ST_HDR;
        end
      end
      ST_HDR: begin
        ctl.selHdr = 1'b1;
        if (outReady) begin
          ctl.loadPtr = 1'b1;
          nextState   = sts.hdrOnly ? ST_NEXT : ST_PAY;
        end
      end
      ST_PAY: if (outReady) begin
        if (sts.payLast) nextState = ST_NEXT;
        else             ctl.stepPtr = 1'b1;
      end
      ST_NEXT: begin
        if (sts.nextOk) begin
          ctl.nextPkt = 1'b1;
          nextState   = ST_LEN;
        end else nextState = ST_DONE;
      end
      ST_DONE: begin
        ctl.clearCount = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cmdWritten <= 1'b0;
      cmdSnap    <= 1'b0;
    end else begin
      state <= nextState;
      if (flushTake)      cmdWritten <= 1'b1;
      else if (frameSync) cmdWritten <= 1'b0;
      if (frameSync)      cmdSnap <= cmdWritten;
    end
  end

  assign wrReady  = (state == ST_IDLE);
  assign outValid = (state == ST_HDR) || (state == ST_PAY);
  assign outFirst = (state == ST_HDR);

endmodule

// File: rtl/texture_packet_walker.sv
module texture_packet_walker
  import texwalk_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  output logic        wrReady,
  input  logic        flushReq,
  input  logic        frameEnd,
  input  logic        frameSync,
  output logic        outValid,
  output logic        outFirst,
  output logic [31:0] outData,
  input  logic        outReady,
  output logic        overflowErr,
  output logic        cmdWritten,
  output logic        cmdSnap
);
  walkCtl_t ctl;
  walkSts_t sts;

  texwalk_store #(.DEPTH(DEPTH), .DW(32)) uStore (
    .clk(clk), .rstN(rstN), .wrEn(wrValid && wrReady), .wrData(wrData),
    .frameEnd(frameEnd), .ctl(ctl), .sts(sts), .rdData(outData),
    .overflowErr(overflowErr)
  );

  texwalk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .frameSync(frameSync),
    .outReady(outReady), .sts(sts), .ctl(ctl), .wrReady(wrReady),
    .outValid(outValid), .outFirst(outFirst), .cmdWritten(cmdWritten),
    .cmdSnap(cmdSnap)
  );

endmodule

// File: rtl/texture_packet_walker_chk.sv
module texture_packet_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrValid,
  input logic        wrReady,
  input logic        flushReq,
  input logic        frameEnd,
  input logic        frameSync,
  input logic        outValid,
  input logic        outFirst,
  input logic [31:0] outData,
  input logic        outReady,
  input logic        overflowErr,
  input logic        cmdWritten,
  input logic        cmdSnap
);
  assert_stall_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !wrReady);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr && !frameEnd |=> overflowErr);

  assert_rise_on_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !overflowErr && !(wrValid && wrReady) |=> !overflowErr);

  assert_flush_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && wrReady |=> cmdWritten);

  assert_sync_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameSync && !(flushReq && wrReady) |=> !cmdWritten);

  assert_snap_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> cmdSnap == $past(cmdWritten));

  assert_first_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFirst));

endmodule

bind texture_packet_walker texture_packet_walker_chk uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .flushReq(flushReq), .frameEnd(frameEnd), .frameSync(frameSync),
  .outValid(outValid), .outFirst(outFirst), .outData(outData),
  .outReady(outReady), .overflowErr(overflowErr), .cmdWritten(cmdWritten),
  .cmdSnap(cmdSnap)
);

// File: tb/tb_texture_packet_walker.sv
module tb_texture_packet_walker;
  localparam int DEPTH = 16;
  typedef logic [31:0] wq_t[$];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        wrReady;
  logic        flushReq = 1'b0;
  logic        frameEnd = 1'b0;
  logic        frameSync = 1'b0;
  logic        outValid, outFirst, outReady;
  logic [31:0] outData;
  logic        overflowErr, cmdWritten, cmdSnap;
  logic [1:0]  rc = 2'd0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R6";
  logic [31:0] expQ[$];
  bit          expF[$];
  bit          prevStall = 0;
  logic [31:0] prevData = '0;
  logic        prevFirst = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) rc <= rc + 2'd1;
  assign outReady = (rc != 2'd1);

  texture_packet_walker #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .flushReq(flushReq), .frameEnd(frameEnd), .frameSync(frameSync),
    .outValid(outValid), .outFirst(outFirst), .outData(outData), .outReady(outReady),
    .overflowErr(overflowErr), .cmdWritten(cmdWritten), .cmdSnap(cmdSnap)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected stream from the packet rules
  task automatic model(input wq_t w);
    longint n, i, len;
    n = (w.size() > DEPTH) ? DEPTH : w.size();
    i = 0;
    if (n > 2) begin
      while (i < n - 2) begin
        len = (2 + longint'(w[i]) / 2) / 4;
        if (len == 0) break;
        expQ.push_back(w[i+1]); expF.push_back(1'b1);
        for (longint j = i + 2; j < i + len && j < n; j++) begin
          expQ.push_back(w[j]); expF.push_back(1'b0);
        end
        i = i + len;
      end
    end
  endtask

  // monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        chk(outValid && outData == prevData && outFirst == prevFirst, "R10",
            "held word", {31'd0, outValid, outData}, {32'd1, prevData});
      if (outValid && outReady) begin
        if (expQ.size() == 0) chk(0, curReq, "unexpected word", outData, 0);
        else begin
          chk(outData == expQ[0] && outFirst == expF[0], curReq, "word/first",
              {outData, 31'd0, outFirst}, {expQ[0], 31'd0, expF[0]});
          void'(expQ.pop_front()); void'(expF.pop_front());
        end
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      prevFirst = outFirst;
    end
  end

  task automatic writeWords(input wq_t w);
    foreach (w[k]) begin
      wrValid = 1'b1; wrData = w[k];
      @(posedge clk); #1;
    end
    wrValid = 1'b0;
  endtask

  task automatic flushAndWait(input string req);
    curReq = req;
    flushReq = 1'b1;
    @(posedge clk); #1;
    flushReq = 1'b0;
    @(negedge clk);
    chk(!wrReady, "R1", "wrReady during walk", wrReady, 0);
    while (!wrReady) @(negedge clk);
    chk(expQ.size() == 0, req, "missing words", expQ.size(), 0);
    @(posedge clk); #1;
  endtask

  task automatic runCase(input wq_t w, input string req);
    model(w);
    writeWords(w);
    flushAndWait(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wq_t big;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(wrReady && !outValid, "R1", "reset handshake", {wrReady, outValid}, 2'b10);
    chk(!overflowErr, "R2", "reset overflow", overflowErr, 0);
    chk(!cmdWritten && !cmdSnap, "R3", "reset flags", {cmdWritten, cmdSnap}, 0);
    @(posedge clk); #1;

    // single packet of length 4 (byte count 28)
    runCase('{32'd28, 32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003}, "R6");
    chk(cmdWritten, "R3", "cmdWritten after flush", cmdWritten, 1);
    frameSync = 1'b1; @(posedge clk); #1; frameSync = 1'b0;
    chk(cmdSnap && !cmdWritten, "R3", "sync snap/clear", {cmdSnap, cmdWritten}, 2'b10);

    // two packets, second one cut at the stored count
    runCase('{32'd20, 32'h1111_0000, 32'h1111_0001,
              32'd36, 32'h2222_0000, 32'h2222_0001, 32'h2222_0002}, "R8");

    // zero length at start
    runCase('{32'd0, 32'h3333_0000, 32'h3333_0001, 32'h3333_0002}, "R7");
    // zero length after a header-only packet (byte count 12 -> length 2)
    runCase('{32'd12, 32'h4444_0000, 32'd1, 32'h4444_0002, 32'h4444_0003}, "R7");

    // under-filled store, then fresh packet lands at index 0
    runCase('{32'd28, 32'h5555_0000}, "R4");
    chk(cmdWritten, "R3", "flag set on empty walk", cmdWritten, 1);
    runCase('{32'd20, 32'h6666_0000, 32'h6666_0001}, "R9");

    // all-ones byte count: huge length clipped to the store
    runCase('{32'hFFFF_FFFF, 32'h7777_0000, 32'h7777_0001, 32'h7777_0002}, "R5");

    // overflow: 18 words into 16 slots, last packet cut at the store end
    big = {};
    for (int p = 0; p < 3; p++) begin
      big.push_back(32'd28); big.push_back(32'h8000_0000 + p);
      big.push_back(32'h8100_0000 + p); big.push_back(32'h8200_0000 + p);
    end
    big.push_back(32'd36); big.push_back(32'h8F00_0000);
    big.push_back(32'h8F00_0001); big.push_back(32'h8F00_0002);
    big.push_back(32'h9000_0000); big.push_back(32'h9000_0001);
    model(big);
    writeWords(big);
    chk(overflowErr, "R2", "overflow set", overflowErr, 1);
    wrValid = 1'b1; wrData = 32'hDEAD_BEEF; frameEnd = 1'b1;
    @(posedge clk); #1;
    wrValid = 1'b0; frameEnd = 1'b0;
    chk(overflowErr, "R2", "set wins over clear", overflowErr, 1);
    flushAndWait("R2");
    chk(overflowErr, "R2", "sticky after walk", overflowErr, 1);
    frameEnd = 1'b1; @(posedge clk); #1; frameEnd = 1'b0;
    chk(!overflowErr, "R2", "frameEnd clears", overflowErr, 0);

    // flush and frame sync in the same cycle
    frameSync = 1'b1; @(posedge clk); #1; frameSync = 1'b0;
    chk(!cmdWritten, "R3", "cleared before combo", cmdWritten, 0);
    flushReq = 1'b1; frameSync = 1'b1;
    @(posedge clk); #1;
    flushReq = 1'b0; frameSync = 1'b0;
    chk(cmdWritten && !cmdSnap, "R3", "flush beats sync", {cmdWritten, cmdSnap}, 2'b10);
    while (!wrReady) @(negedge clk);
    @(posedge clk); #1;

    // store is empty again: a new packet starts at index 0
    runCase('{32'd28, 32'hAAAA_0000, 32'hAAAA_0001, 32'hAAAA_0002, 32'd0}, "R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule